// File: doc/BRIEF.md
# Register Hazard Issue Scoreboard

This block is the central issue controller of a small multi-unit core that has no register renaming. Each decoded register-to-register instruction arrives with two source register numbers, a destination register number and the execution unit it needs, under a valid/ready handshake. The block holds one instruction per execution unit and decides three things each cycle:

- whether the offered instruction may be assigned to its unit;
- whether each assigned unit may start, which is the moment it reads its operands;
- whether each unit that has finished may write its result back.

The block does no arithmetic. Each execution unit reports the end of its work with a one-cycle completion strobe.

Hazards are settled by stalling, because every register name has exactly one storage location. Read-after-write holds a unit before its start. Write-after-write freezes the handshake, and with it all further assignment to every unit. Write-after-read holds only the write of the unit that would clobber a value some earlier instruction has not read yet; the other units keep taking and finishing work. A per-register table records which unit will write each register. Units may finish out of program order.

Top module: `scb_issue_ctrl`

## Requirements
- R1: After reset all units are idle: `in_ready` is high for any instruction, and `start_o`, `wr_en_o`, `assign_oh` and `wr_reg_o` are all zero.
- R2: A unit's `start_o` is never high in the cycle its instruction is accepted. It pulses in the first later cycle in which neither source register has a pending writer. A source is treated as free if it has no pending writer at acceptance, or if its writer's write enable is high in the acceptance cycle. Otherwise it becomes free in the cycle after that writer's `wr_en_o`.
- R3: While the offered destination register has a pending writer, `in_ready` is low whatever unit is requested. `in_ready` returns no earlier than the cycle after that writer's `wr_en_o`.
- R4: A unit that has finished keeps `wr_en_o` low while an earlier-assigned unit that has not yet started still has to read the finishing unit's destination register. Meanwhile the other units still start and write. The held unit writes in the cycle after the reader's `start_o`.
- R5: While the requested unit (`in_unit`, unit index 0 to NUM_UNITS-1) holds an instruction, `in_ready` is low for that instruction only. The unit can be assigned again from the cycle after its `wr_en_o`.
- R6: With no write-after-read conflict, `wr_en_o` of a unit is high in the same cycle as its completion strobe. `wr_reg_o` then has exactly the bit of that unit's destination register set.
- R7: Instructions on different units may write back out of program order.
- R8: `assign_oh` is the one-hot code of `in_unit` in a cycle where `in_valid` and `in_ready` are both high, and zero otherwise.
- R9: Each accepted instruction gives exactly one `start_o` pulse and one `wr_en_o` pulse. A completion strobe from a unit that is not executing has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Offered instruction can be assigned this cycle |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_dst | input | REG_W | Destination register |
| in_unit | input | UNIT_W | Execution unit required |
| done_i | input | NUM_UNITS | Per-unit completion strobes |
| assign_oh | output | NUM_UNITS | One-hot unit receiving the accepted instruction |
| start_o | output | NUM_UNITS | Per-unit start (operand read) pulses |
| wr_en_o | output | NUM_UNITS | Per-unit write-back grants |
| wr_reg_o | output | NUM_REGS | Register file write enables, one per register |

## Verification
The most delicate coincidence is a write-back in the same cycle as something else that depends on that register. One case is a write-back in the cycle a new instruction reading that register is accepted. The other is a held writer releasing in the cycle after its reader starts, while a third unit also completes. Both are provoked by a directed sequence built on units with latencies 1, 2, 3 and 5 cycles. A long run of random instructions over eight registers then follows; it also injects spurious completion strobes. Every cycle the bench predicts `in_ready`, `assign_oh`, `start_o`, `wr_en_o` and `wr_reg_o` from its own model of the rules and compares all five.

// File: rtl/scb_pkg.sv
// Package: shared types for the register hazard issue scoreboard.
// Assumes nothing beyond a single clock domain.
package scb_pkg;

    // Life cycle of one execution unit slot.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,   // no instruction held
        SLOT_WAIT = 2'd1,   // assigned, waiting for source operands
        SLOT_EXEC = 2'd2,   // operands read, unit computing
        SLOT_HOLD = 2'd3    // result ready, write held by a pending reader
    } slot_state_e;

endpackage

// File: rtl/scb_pend_table.sv
// Module: per-register pending-writer table.
// Each register has a valid bit and the index of the unit that will write it.
// Assumes set and clear of the same register never coincide, because the
// top refuses a second writer to a register that is still pending.
module scb_pend_table #(
    parameter int NUM_REGS  = 8,
    parameter int NUM_UNITS = 4,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               set_en,
    input  logic [REG_W-1:0]                   set_reg,
    input  logic [UNIT_W-1:0]                  set_unit,
    input  logic [NUM_UNITS-1:0]               unit_wr,
    output logic [NUM_REGS-1:0]                pend_vld,
    output logic [NUM_REGS-1:0][UNIT_W-1:0]    pend_unit
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic clr_r;
        // The recorded owner releasing its write clears the entry.
        assign clr_r = pend_vld[r] && unit_wr[pend_unit[r]];

        // Hold the pending flag and owner of register r.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_vld[r]  <= 1'b0;
                pend_unit[r] <= '0;
            end else if (set_en && (set_reg == REG_W'(r))) begin
                pend_vld[r]  <= 1'b1;
                pend_unit[r] <= set_unit;
            end else if (clr_r) begin
                pend_vld[r]  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scb_unit_slot.sv
// Module: issue state for one execution unit.
// Holds the assigned instruction's registers and per-source ready bits.
// Raises start when both sources are ready. Grants the write on completion
// unless a write-after-read block is present, in which case it holds.
// Assumes done_i is meaningful only while the slot is executing.
module scb_unit_slot
    import scb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 assign_en,
    input  logic [REG_W-1:0]     src_a,
    input  logic [REG_W-1:0]     src_b,
    input  logic [REG_W-1:0]     dst,
    input  logic                 rdy_a_init,
    input  logic                 rdy_b_init,
    input  logic [NUM_REGS-1:0]  reg_written,
    input  logic                 done_i,
    input  logic                 war_block,
    output logic                 busy_o,
    output logic                 start_o,
    output logic                 wr_en_o,
    output logic [REG_W-1:0]     dst_o,
    output logic [NUM_REGS-1:0]  need_o
);

    slot_state_e      state_q;
    logic [REG_W-1:0] sa_q, sb_q, d_q;
    logic             ra_q, rb_q;
    logic             finish;

    // Start, finish and write-grant decisions for this cycle.
    always_comb begin
        start_o = (state_q == SLOT_WAIT) && ra_q && rb_q;
        finish  = (state_q == SLOT_EXEC) && done_i;
        wr_en_o = (finish || (state_q == SLOT_HOLD)) && !war_block;
    end

    assign busy_o = (state_q != SLOT_IDLE);
    assign dst_o  = d_q;

    // Registers this slot has yet to read whose current value is the one it wants.
    always_comb begin
        need_o = '0;
        if (state_q == SLOT_WAIT) begin
            if (ra_q) need_o[sa_q] = 1'b1;
            if (rb_q) need_o[sb_q] = 1'b1;
        end
    end

    // Slot state, captured registers and ready bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            sa_q    <= '0;
            sb_q    <= '0;
            d_q     <= '0;
            ra_q    <= 1'b0;
            rb_q    <= 1'b0;
        end else begin
            case (state_q)
                SLOT_IDLE: begin
                    if (assign_en) begin
                        state_q <= SLOT_WAIT;
                        sa_q    <= src_a;
                        sb_q    <= src_b;
                        d_q     <= dst;
                        ra_q    <= rdy_a_init;
                        rb_q    <= rdy_b_init;
                    end
                end
                SLOT_WAIT: begin
                    ra_q <= ra_q || reg_written[sa_q];
                    rb_q <= rb_q || reg_written[sb_q];
                    if (start_o) state_q <= SLOT_EXEC;
                end
                SLOT_EXEC: begin
                    if (wr_en_o)     state_q <= SLOT_IDLE;
                    else if (finish) state_q <= SLOT_HOLD;
                end
                default: begin
                    if (wr_en_o) state_q <= SLOT_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/scb_issue_ctrl.sv
// Module: register hazard issue scoreboard (top).
// Takes one decoded instruction at a time. Gates assignment on unit
// availability and on write-after-write; slots gate start on read-after-write;
// write-back is gated per unit on write-after-read.
// Assumes in_unit < NUM_UNITS and one done_i strobe per started instruction.
module scb_issue_ctrl
    import scb_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int NUM_UNITS = 4,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [REG_W-1:0]      in_src_a,
    input  logic [REG_W-1:0]      in_src_b,
    input  logic [REG_W-1:0]      in_dst,
    input  logic [UNIT_W-1:0]     in_unit,
    input  logic [NUM_UNITS-1:0]  done_i,
    output logic [NUM_UNITS-1:0]  assign_oh,
    output logic [NUM_UNITS-1:0]  start_o,
    output logic [NUM_UNITS-1:0]  wr_en_o,
    output logic [NUM_REGS-1:0]   wr_reg_o
);

    logic [NUM_REGS-1:0]              pend_vld;
    logic [NUM_REGS-1:0][UNIT_W-1:0]  pend_unit;
    logic [NUM_UNITS-1:0]             slot_busy;
    logic [NUM_UNITS-1:0]             war_block;
    logic [NUM_UNITS-1:0][REG_W-1:0]  slot_dst;
    logic [NUM_UNITS-1:0][NUM_REGS-1:0] slot_need;
    logic                             accept;
    logic                             rdy_a_init, rdy_b_init;

    // Assignment gate: requested unit free and no pending writer of the destination.
    always_comb begin
        in_ready = !slot_busy[in_unit] && !pend_vld[in_dst];
        accept   = in_valid && in_ready;
        for (int u = 0; u < NUM_UNITS; u++)
            assign_oh[u] = accept && (in_unit == UNIT_W'(u));
    end

    // Source readiness at assignment, counting a write-back in this very cycle.
    always_comb begin
        rdy_a_init = !pend_vld[in_src_a] || wr_reg_o[in_src_a];
        rdy_b_init = !pend_vld[in_src_b] || wr_reg_o[in_src_b];
    end

    // Register file write enables decoded from the granted units.
    always_comb begin
        wr_reg_o = '0;
        for (int u = 0; u < NUM_UNITS; u++)
            if (wr_en_o[u]) wr_reg_o[slot_dst[u]] = 1'b1;
    end

    // Write-after-read block: another slot still has to read this slot's destination.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            logic [NUM_REGS-1:0] others;
            others = '0;
            for (int v = 0; v < NUM_UNITS; v++)
                if (v != u) others = others | slot_need[v];
            war_block[u] = others[slot_dst[u]];
        end
    end

    scb_pend_table #(
        .NUM_REGS  (NUM_REGS),
        .NUM_UNITS (NUM_UNITS)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (accept),
        .set_reg   (in_dst),
        .set_unit  (in_unit),
        .unit_wr   (wr_en_o),
        .pend_vld  (pend_vld),
        .pend_unit (pend_unit)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
        scb_unit_slot #(
            .NUM_REGS (NUM_REGS)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .assign_en   (assign_oh[u]),
            .src_a       (in_src_a),
            .src_b       (in_src_b),
            .dst         (in_dst),
            .rdy_a_init  (rdy_a_init),
            .rdy_b_init  (rdy_b_init),
            .reg_written (wr_reg_o),
            .done_i      (done_i[u]),
            .war_block   (war_block[u]),
            .busy_o      (slot_busy[u]),
            .start_o     (start_o[u]),
            .wr_en_o     (wr_en_o[u]),
            .dst_o       (slot_dst[u]),
            .need_o      (slot_need[u])
        );
    end

endmodule

// File: rtl/scb_issue_ctrl_chk.sv
// Module: property checker for the issue scoreboard, bound to the top.
// Assumes the bench holds rst_n low at time zero.
module scb_issue_ctrl_chk #(
    parameter int NUM_REGS  = 8,
    parameter int NUM_UNITS = 4,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [REG_W-1:0]      in_dst,
    input logic [NUM_UNITS-1:0]  assign_oh,
    input logic [NUM_UNITS-1:0]  start_o,
    input logic [NUM_UNITS-1:0]  wr_en_o,
    input logic [NUM_REGS-1:0]   wr_reg_o,
    input logic [NUM_REGS-1:0]   pend_vld
);

    assert_assign_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(assign_oh) && ((in_valid && in_ready) == (assign_oh != '0)));

    assert_waw_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !(in_valid && in_ready && (in_dst == $past(in_dst))));

    assert_unit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (assign_oh != '0) |=> ((assign_oh & $past(assign_oh)) == '0));

    assert_wr_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_reg_o) == $countones(wr_en_o));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
        assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wr_reg_o[r] |-> pend_vld[r] ##1 !pend_vld[r]);
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_chk
        assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[u] |=> !start_o[u]);
        assert_no_start_on_assign_R2: assert property (@(posedge clk) disable iff (!rst_n)
            assign_oh[u] |-> !start_o[u]);
        assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_o[u] |=> !wr_en_o[u]);
    end

endmodule

bind scb_issue_ctrl scb_issue_ctrl_chk #(
    .NUM_REGS  (NUM_REGS),
    .NUM_UNITS (NUM_UNITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_dst    (in_dst),
    .assign_oh (assign_oh),
    .start_o   (start_o),
    .wr_en_o   (wr_en_o),
    .wr_reg_o  (wr_reg_o),
    .pend_vld  (pend_vld)
);

// File: tb/scb_issue_ctrl_tb.sv
// Bench: directed hazard sequence, then seeded random instructions, with a
// per-cycle prediction of every output from a model of the requirements.
module scb_issue_ctrl_tb;

    localparam int NR = 8;
    localparam int NU = 4;
    localparam int LAT [NU] = '{1, 2, 3, 5};
    localparam int RANDOM_STEPS = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic [1:0] in_unit = '0;
    logic [NU-1:0] done_i = '0;
    logic [NU-1:0] assign_oh, start_o, wr_en_o;
    logic [NR-1:0] wr_reg_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scb_issue_ctrl #(.NUM_REGS(NR), .NUM_UNITS(NU)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .in_unit(in_unit), .done_i(done_i), .assign_oh(assign_oh),
        .start_o(start_o), .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o)
    );

    // Reference model state.
    bit m_busy [NU], m_started [NU], m_hold [NU], m_r1 [NU], m_r2 [NU];
    int m_dst [NU], m_s1 [NU], m_s2 [NU], m_cnt [NU], m_seq [NU];
    bit m_pend [NR];
    int seq_ctr = 0;

    // Offered instruction.
    bit has_ins = 1'b0;
    int ins_u, ins_d, ins_a, ins_b;

    // Coverage flags for named end checks.
    int seen_war = 0, seen_waw = 0, seen_struct = 0, seen_ooo = 0, seen_spur = 0;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_busy[u] = 0; m_started[u] = 0; m_hold[u] = 0;
            m_r1[u] = 0; m_r2[u] = 0; m_cnt[u] = 0;
        end
        for (int r = 0; r < NR; r++) m_pend[r] = 0;
    endtask

    // One clock: drive at the falling edge, compare, then advance the model at the rising edge.
    task automatic step(bit spurious);
        logic [NU-1:0] dn, e_start, e_wr, e_asg;
        logic [NR-1:0] e_wreg;
        bit e_ready, acc;
        @(negedge clk);
        dn = '0;
        for (int u = 0; u < NU; u++) begin
            if (m_busy[u] && m_started[u] && !m_hold[u]) dn[u] = (m_cnt[u] == 0);
            else if (spurious && ($urandom % 8 == 0)) begin dn[u] = 1'b1; seen_spur++; end
        end
        done_i   = dn;
        in_valid = has_ins;
        in_unit  = 2'(ins_u); in_dst = 3'(ins_d);
        in_src_a = 3'(ins_a); in_src_b = 3'(ins_b);
        #2;
        // Expected outputs from the model.
        e_ready = !m_busy[in_unit] && !m_pend[in_dst];
        acc = has_ins && e_ready;
        e_asg = acc ? (NU'(1) << ins_u) : '0;
        e_wreg = '0;
        for (int u = 0; u < NU; u++) begin
            bit war;
            war = 0;
            for (int v = 0; v < NU; v++)
                if (v != u && m_busy[v] && !m_started[v] &&
                    ((m_s1[v] == m_dst[u] && m_r1[v]) || (m_s2[v] == m_dst[u] && m_r2[v])))
                    war = 1;
            e_start[u] = m_busy[u] && !m_started[u] && m_r1[u] && m_r2[u];
            e_wr[u] = m_busy[u] && m_started[u] && (m_hold[u] || dn[u]) && !war;
            if (e_wr[u]) e_wreg[m_dst[u]] = 1'b1;
            if (m_busy[u] && m_started[u] && !m_hold[u] && dn[u] && war) seen_war++;
        end
        if (has_ins && !m_busy[ins_u] && m_pend[ins_d]) seen_waw++;
        if (has_ins && m_busy[ins_u]) seen_struct++;
        check("R3 R5", "in_ready", in_ready, e_ready);
        check("R8", "assign_oh", assign_oh, e_asg);
        check("R2 R9", "start_o", start_o, e_start);
        check("R4 R6", "wr_en_o", wr_en_o, e_wr);
        check("R6", "wr_reg_o", wr_reg_o, e_wreg);
        @(posedge clk);
        // Advance the model with the decisions of this cycle.
        for (int u = 0; u < NU; u++) begin
            if (e_wr[u]) begin
                for (int v = 0; v < NU; v++)
                    if (v != u && m_busy[v] && m_seq[v] < m_seq[u]) seen_ooo++;
                m_busy[u] = 0; m_started[u] = 0; m_hold[u] = 0;
                m_pend[m_dst[u]] = 0;
                for (int v = 0; v < NU; v++) begin
                    if (m_s1[v] == m_dst[u]) m_r1[v] = 1;
                    if (m_s2[v] == m_dst[u]) m_r2[v] = 1;
                end
            end else if (m_busy[u] && m_started[u] && !m_hold[u]) begin
                if (dn[u]) m_hold[u] = 1;
                else m_cnt[u]--;
            end
            if (e_start[u]) begin m_started[u] = 1; m_cnt[u] = LAT[u] - 1; end
        end
        if (acc) begin
            m_busy[ins_u] = 1; m_started[ins_u] = 0; m_hold[ins_u] = 0;
            m_dst[ins_u] = ins_d; m_s1[ins_u] = ins_a; m_s2[ins_u] = ins_b;
            m_r1[ins_u] = !m_pend[ins_a] || e_wreg[ins_a];
            m_r2[ins_u] = !m_pend[ins_b] || e_wreg[ins_b];
            m_seq[ins_u] = seq_ctr++;
            m_pend[ins_d] = 1;
            has_ins = 0;
        end
    endtask

    task automatic offer(int u, int d, int a, int b);
        has_ins = 1; ins_u = u; ins_d = d; ins_a = a; ins_b = b;
        while (has_ins) step(1'b0);
    endtask

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        ins_u = 0; ins_d = 0; ins_a = 0; ins_b = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle state after reset.
        @(negedge clk); #2;
        check("R1", "in_ready idle", in_ready, 1);
        check("R1", "start idle", start_o, 0);
        check("R1", "wr idle", wr_en_o, 0);
        check("R1", "assign idle", assign_oh, 0);
        check("R1", "wr_reg idle", wr_reg_o, 0);
        // Directed: long writer, RAW reader, WAR clobber, independent unit, WAW, structural.
        offer(3, 1, 5, 6);   // slow writer of r1
        offer(0, 2, 1, 7);   // R2: waits on r1, holds old r7
        offer(1, 7, 3, 4);   // R4: finishes early but must not clobber r7
        offer(2, 4, 0, 0);   // R7: finishes before the slow writer
        offer(2, 2, 0, 0);   // R3 / R5: destination r2 pending, unit 2 busy
        offer(1, 3, 2, 2);
        repeat (12) step(1'b1);
        // R9: spurious strobes to idle units must change nothing.
        repeat (6) step(1'b1);
        // Random phase.
        for (int i = 0; i < RANDOM_STEPS; i++) begin
            if (!has_ins && ($urandom % 4 != 0)) begin
                has_ins = 1;
                ins_u = $urandom % NU; ins_d = $urandom % NR;
                ins_a = $urandom % NR; ins_b = $urandom % NR;
            end
            step(1'b1);
        end
        has_ins = 0;
        repeat (20) step(1'b0);
        check("R4", "write-after-read holds seen", seen_war > 0, 1);
        check("R3", "write-after-write stalls seen", seen_waw > 0, 1);
        check("R5", "busy-unit stalls seen", seen_struct > 0, 1);
        check("R7", "out-of-order write-back seen", seen_ooo > 0, 1);
        check("R9", "spurious strobes applied", seen_spur > 0, 1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule